// File: doc/BRIEF.md
# Hiccup Startup and Fault Restart Timer

This block decides when a boost converter's switching stage may run. After power-up it holds the converter off until the dimming input is first seen high. Only then does it start a restart delay that is counted in switching cycles, not in absolute time. A prescaler divides the switching-cycle ticks by `PRE_DIV`, and a restart counter counts the prescaled steps up to `TERM_CNT`. Once the count is complete, the gate drivers are allowed to run and the clamp on the compensation node is released.

The over-voltage and over-current flags arrive as already-hysteretic digital levels. While either flag is high, a fault latch is set, the converter is held off, the compensation node is clamped, and the prescaler and counter are held at zero. When both flags drop, the same timed restart runs again. When the restart completes, the fault latch clears. The count saturates at its terminal value and stays there until the next fault or reset. With the default parameters the restart delay is 1024 switching cycles.

Top module: `hiccup_start_timer`

## Requirements
- R1: While reset is asserted and directly after reset, `run_en` is 0 and `comp_clamp` is 1.
- R2: Until `dim_in` is sampled high for the first time after reset, `run_en` stays 0, however many `sw_tick` pulses arrive.
- R3: Call edge d the first clock edge that samples `dim_in` high. A tick at edge d is not counted. Ticks at later edges are counted. `run_en` goes to 1 one clock edge after the edge that carries the (`PRE_DIV`*`TERM_CNT`)-th counted tick. It is 0 before that.
- R4: Only edges where `sw_tick` is 1 advance the delay. Spacing the ticks N clocks apart stretches the delay in clock cycles by a factor of N.
- R5: An edge that samples `ovp_flag` high makes `run_en` 0 right after that edge. `run_en` stays 0 while the flag remains high.
- R6: `ocp_flag` acts in the same way as `ovp_flag`.
- R7: Call the first edge at which both fault flags are sampled low the release edge. Ticks are counted from the release edge onwards, including that edge. `run_en` returns to 1 one edge after the (`PRE_DIV`*`TERM_CNT`)-th counted tick.
- R8: A fault that arrives during a restart delay clears the progress made so far. The full delay restarts from the next release edge.
- R9: Once `run_en` is 1, it stays 1 while no fault flag is high. Later changes of `dim_in` have no effect.
- R10: `comp_clamp` is always the inverse of `run_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_tick | input | 1 | One-clock pulse for each switching cycle |
| dim_in | input | 1 | Dimming level; the first high sample arms the startup |
| ovp_flag | input | 1 | Over-voltage condition (hysteretic level) |
| ocp_flag | input | 1 | Over-current condition |
| run_en | output | 1 | Gate drivers allowed to switch |
| comp_clamp | output | 1 | Request to discharge and hold the compensation node |

## Verification
A fault flag takes effect on the same edge that samples it, so the bench reads `run_en` one time unit after that edge. A release is due one edge after the final counted tick. For tick period p, that is edge (`PRE_DIV`*`TERM_CNT`-1)*p+1 counted from the release edge (edge 0). The bench compares `run_en` and `comp_clamp` with this arithmetic value after every edge of each restart window. An early release or a late release therefore fails at the exact cycle where it happens. Inputs change only on falling clock edges, so every sample lines up with a known rising edge.

// File: rtl/hs_pkg.sv
package hs_pkg;
  // width of a counter holding values 0..n-1, never below one bit
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/hs_rst_sync.sv
module hs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/hs_prescaler.sv
module hs_prescaler #(
  parameter int unsigned PRE_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic tick,
  output logic step
);
  localparam int unsigned PW = hs_pkg::cnt_width(PRE_DIV);
  localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          wrap;

  always_comb begin
    wrap  = tick && en && !clr && (pre_q == LAST);
    pre_d = pre_q;
    if (clr)              pre_d = '0;
    else if (tick && en)  pre_d = wrap ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign step = wrap;
endmodule

// File: rtl/hs_restart_counter.sv
module hs_restart_counter #(
  parameter int unsigned TERM_CNT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic done
);
  localparam int unsigned CW = hs_pkg::cnt_width(TERM_CNT + 1);
  localparam logic [CW-1:0] TERM = CW'(TERM_CNT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_term;

  always_comb begin
    at_term = (cnt_q == TERM);
    cnt_d   = cnt_q;
    if (clr)                  cnt_d = '0;
    else if (step && !at_term) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = at_term;
endmodule

// File: rtl/hs_arm_latches.sv
module hs_arm_latches (
  input  logic clk,
  input  logic rst_n,
  input  logic dim_in,
  input  logic fault_now,
  input  logic term_hit,
  output logic por_q,
  output logic flt_q
);
  logic por_d, flt_d;

  always_comb begin
    // power-on latch clears on the first high dimming sample, never re-arms
    por_d = por_q && !dim_in;
    // fault latch: set by a live fault, cleared when the restart completes
    if (fault_now)     flt_d = 1'b1;
    else if (term_hit) flt_d = 1'b0;
    else               flt_d = flt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_q <= 1'b1;
      flt_q <= 1'b1;
    end else begin
      por_q <= por_d;
      flt_q <= flt_d;
    end
  end
endmodule

// File: rtl/hiccup_start_timer.sv
module hiccup_start_timer #(
  parameter int unsigned PRE_DIV  = 4,
  parameter int unsigned TERM_CNT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_tick,
  input  logic dim_in,
  input  logic ovp_flag,
  input  logic ocp_flag,
  output logic run_en,
  output logic comp_clamp
);
  logic rst_core_n;
  logic fault_now;
  logic hold;
  logic por_q, flt_q;
  logic step, term_hit;

  hs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  assign fault_now = ovp_flag | ocp_flag;
  assign hold      = por_q | fault_now;

  hs_arm_latches u_latch (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .dim_in    (dim_in),
    .fault_now (fault_now),
    .term_hit  (term_hit),
    .por_q     (por_q),
    .flt_q     (flt_q)
  );

  hs_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (hold),
    .en    (!term_hit),
    .tick  (sw_tick),
    .step  (step)
  );

  hs_restart_counter #(.TERM_CNT(TERM_CNT)) u_cnt (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (hold),
    .step  (step),
    .done  (term_hit)
  );

  assign run_en     = !flt_q && !por_q && term_hit;
  assign comp_clamp = !run_en;
endmodule

// File: rtl/hs_chk.sv
module hs_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_tick,
  input logic dim_in,
  input logic ovp_flag,
  input logic ocp_flag,
  input logic run_en,
  input logic comp_clamp
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_q | dim_in;
  end

  // R2
  no_run_before_dim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !run_en);

  // R5 R6
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_flag || ocp_flag) |=> !run_en);

  // R7
  rise_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> !$past(ovp_flag || ocp_flag));

  // R9
  hold_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !ovp_flag && !ocp_flag) |=> run_en);

  // R10
  clamp_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comp_clamp != run_en);
endmodule

bind hiccup_start_timer hs_chk chk_i (.*);

// File: tb/hiccup_start_timer_tb_top.sv
`timescale 1ns/1ps
module hiccup_start_timer_tb_top;
  localparam int PRE  = 4;
  localparam int TERM = 8;
  localparam int WIN  = PRE * TERM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_tick = 1'b0, dim_in = 1'b0, ovp_flag = 1'b0, ocp_flag = 1'b0;
  logic run_en, comp_clamp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hiccup_start_timer #(.PRE_DIV(PRE), .TERM_CNT(TERM)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_tick(sw_tick), .dim_in(dim_in),
    .ovp_flag(ovp_flag), .ocp_flag(ocp_flag),
    .run_en(run_en), .comp_clamp(comp_clamp)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic t);
    @(negedge clk);
    sw_tick = t;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_out(input string req, input logic exp);
    chk(req, run_en, exp);
    chk("R10", comp_clamp, !exp);
  endtask

  // window: edge k=0 is the first counted edge; release due after edge E+1
  task automatic window(input int period, input string req);
    int e;
    e = (WIN - 1) * period;
    for (int k = 0; k <= e + 3; k++) begin
      step((k % period) == 0);
      chk_out(req, (k >= e + 1));
    end
  endtask

  task automatic fault_cycle(input bit use_ocp, input int period, input string req);
    if (use_ocp) ocp_flag = 1'b1; else ovp_flag = 1'b1;
    step(1'b1);
    chk_out(req, 1'b0);
    for (int i = 0; i < 3 * WIN; i++) begin
      step((i % period) == 0);
      chk_out(req, 1'b0);
    end
    ovp_flag = 1'b0;
    ocp_flag = 1'b0;
    window(period, "R7");
  endtask

  initial begin
    #5;
    chk_out("R1", 1'b0);
    repeat (3) @(posedge clk);
    #1;
    chk_out("R1", 1'b0);
    rst_n = 1'b1;
    repeat (4) step(1'b0);
    chk_out("R1", 1'b0);

    // R2: ticks without any dimming pulse
    for (int i = 0; i < 4 * WIN; i++) begin
      step(1'b1);
      chk_out("R2", 1'b0);
    end

    // R3: first dimming pulse; tick at that edge is not counted
    @(negedge clk);
    dim_in = 1'b1;
    sw_tick = 1'b1;
    @(posedge clk); #1;
    chk_out("R3", 1'b0);
    dim_in = 1'b0;
    window(1, "R3");

    // R9: stays running, dimming toggles ignored
    for (int i = 0; i < 3 * WIN; i++) begin
      dim_in = i[1];
      step(1'b1);
      chk_out("R9", 1'b1);
    end
    dim_in = 1'b0;

    // R5 / R6 / R4: fault sweep over tick spacings
    for (int p = 1; p <= 3; p++) begin
      fault_cycle(1'b0, p, "R5");
      fault_cycle(1'b1, p, "R6");
    end
    // R4 extra spacing
    ovp_flag = 1'b1;
    step(1'b0);
    ovp_flag = 1'b0;
    window(5, "R4");

    // R8: fault in the middle of a restart clears progress
    for (int m = 1; m < WIN; m += 7) begin
      ocp_flag = 1'b1;
      step(1'b1);
      chk_out("R6", 1'b0);
      ocp_flag = 1'b0;
      for (int i = 0; i < m; i++) begin
        step(1'b1);
        chk_out("R8", 1'b0);
      end
      ovp_flag = 1'b1;
      step(1'b1);
      chk_out("R8", 1'b0);
      ovp_flag = 1'b0;
      window(1, "R8");
    end

    // R9: long run afterwards
    for (int i = 0; i < 2 * WIN; i++) begin
      step(i[0]);
      chk_out("R9", 1'b1);
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule